// File: doc/BRIEF.md
# Full-Duplex Serial Transceiver with Abortable Directions

This block is an asynchronous serial transceiver that sends and receives at the same time. A small register interface on the bus side holds the control byte, the status flags, a transmit holding register and a receive data register. A transmit shifter and a receive shifter move each frame one bit at a time. One clock-enable input, `tick16`, sets the timing. It pulses at sixteen times the bit rate, and every bit lasts sixteen of these pulses.

A frame is a low start bit, eight data bits sent least significant bit first, an optional even parity bit and a high stop bit. The receiver passes the line through two synchroniser stages and votes among three samples taken near the middle of each bit. Software can clear either direction's enable bit at any moment. Clearing it aborts the frame in progress and returns that direction to its idle state. A transmit abort raises both transmit flags. A receive abort leaves every flag and the receive data register as they were. Three interrupt lines are each registered from the status flags and their mask bits in the control byte.

Top module: `uart_core`

## Requirements
- R1: After reset the control byte reads 0x00. The status byte reads 0x01, with only buffer-empty set. `txd` is 1 and all three interrupt lines are 0.
- R2: Each frame on `txd` is a 0 start bit, then data bits 0 to 7, then an even parity bit (the XOR of the data) when control bit 5 is 1, then a 1 stop bit. Every bit lasts 16 `tick16` pulses, and the line is 1 between frames.
- R3: The receiver takes a majority vote of three samples near the middle of each bit, so a glitch of one clock inside a bit is ignored. A completed frame loads the receive data register (address 3) and sets receive-full (status bit 2). A read of address 3 clears receive-full.
- R4: When control bit 5 is 1 and the received parity bit differs from the XOR of the data, parity-error (status bit 5) is set. A stop bit sampled as 0 sets framing-error (status bit 3).
- R5: When a frame completes while receive-full is 1, overrun (status bit 4) is set. The new byte is dropped and the register keeps the old byte.
- R6: Writing 0 to receive-enable (control bit 4) during a frame stops the receiver at once. The partial byte is not stored, and status bits 2 to 5 and the receive data register are left unchanged. Once re-enabled, the receiver accepts the next full frame correctly.
- R7: Writing 0 to transmit-enable (control bit 3) stops the transmitter at once. Buffer-empty (bit 0) and complete (bit 1) both read 1 right after the write, and `txd` is 1 from the next clock onward.
- R8: `irq_rx` is 1 one clock after receive-interrupt-enable (control bit 2) is 1 together with any of status bits 2, 3, 4 or 5.
- R9: `irq_txdone` follows complete (bit 1) AND control bit 1, one clock later. Complete is set when a frame ends and no byte is waiting.
- R10: `irq_txempty` follows buffer-empty (bit 0) AND control bit 0, one clock later.
- R11: Writing address 2 loads the transmit byte and clears buffer-empty and complete. Writing address 1 with bit 7 set clears status bits 3, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect at address 3) |
| bus_addr | input | 2 | 0 control, 1 status, 2 transmit data, 3 receive data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, 1 when idle |
| irq_rx | output | 1 | Receive data or error interrupt |
| irq_txdone | output | 1 | Transmission-complete interrupt |
| irq_txempty | output | 1 | Transmit-buffer-empty interrupt |

## Verification
A transmit shifter left in a wrong state after an abort would show on `txd` as a low level one clock after the control write. It would also leave the two transmit flags low when the status is read in that same cycle. A receive shifter that is not cleared on abort would corrupt the next byte after re-enable, visible at the data register one frame later. A vote or bit-index error appears at the latest at the end of the affected frame, as a wrong byte or a spurious parity or framing flag. A broken flag-to-interrupt path shows on the interrupt pins two clocks after the register write that arms it.

// File: rtl/uart_pkg.sv
package uart_pkg;
    localparam int DW  = 8;
    localparam int OSR = 16;

    localparam int C_TEIE = 0;
    localparam int C_TCIE = 1;
    localparam int C_RIE  = 2;
    localparam int C_TXE  = 3;
    localparam int C_RXE  = 4;
    localparam int C_PEN  = 5;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_TXD  = 2'd2;
    localparam logic [1:0] A_RXD  = 2'd3;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
#(
    parameter int W = DW,
    parameter int R = OSR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         par_en,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         txd,
    output logic         busy,
    output logic         done
);
    localparam int SW = $clog2(R);
    localparam int CW = $clog2(W + 4);
    localparam logic [SW-1:0] SUB_END  = SW'(R - 1);
    localparam logic [CW-1:0] LAST_PAR = CW'(W + 2);
    localparam logic [CW-1:0] LAST_NOP = CW'(W + 1);

    typedef struct packed {
        logic          busy;
        logic [SW-1:0] sub;
        logic [CW-1:0] idx;
        logic [W+2:0]  sh;
        logic          txd;
    } tx_state_t;

    tx_state_t q, d;
    logic [CW-1:0] last_idx;

    always_comb begin
        d        = q;
        done     = 1'b0;
        last_idx = par_en ? LAST_PAR : LAST_NOP;
        if (!en) begin
            d.busy = 1'b0;
            d.sub  = '0;
            d.idx  = '0;
            d.txd  = 1'b1;
        end else if (!q.busy) begin
            if (load) begin
                d.busy = 1'b1;
                d.sub  = '0;
                d.idx  = '0;
                d.sh   = {1'b1, (par_en ? ^din : 1'b1), din, 1'b0};
                d.txd  = 1'b0;
            end
        end else if (tick) begin
            if (q.sub == SUB_END) begin
                d.sub = '0;
                if (q.idx == last_idx) begin
                    d.busy = 1'b0;
                    d.txd  = 1'b1;
                    done   = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                    d.sh  = {1'b1, q.sh[W+2:1]};
                    d.txd = q.sh[1];
                end
            end else begin
                d.sub = q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.busy <= 1'b0;
            q.sub  <= '0;
            q.idx  <= '0;
            q.sh   <= '1;
            q.txd  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd  = q.txd;
    assign busy = q.busy;

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> q.txd); // R2
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
#(
    parameter int W = DW,
    parameter int R = OSR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         par_en,
    input  logic         rxd,
    output logic         done,
    output logic [W-1:0] dout,
    output logic         perr,
    output logic         ferr
);
    localparam int SW = $clog2(R);
    localparam int CW = $clog2(W + 4);
    localparam logic [SW-1:0] SUB_END = SW'(R - 1);
    localparam logic [SW-1:0] SMP_C   = SW'(R / 2);
    localparam logic [SW-1:0] SMP_B   = SW'(R / 2 - 1);
    localparam logic [SW-1:0] SMP_A   = SW'(R / 2 - 2);
    localparam logic [CW-1:0] IDX_PAR = CW'(W + 1);
    localparam logic [CW-1:0] IDX_DAT = CW'(W);

    typedef struct packed {
        logic [1:0]    sy;
        logic          busy;
        logic [SW-1:0] sub;
        logic [CW-1:0] idx;
        logic          va;
        logic          vb;
        logic [W-1:0]  sh;
        logic          pbit;
        logic          done;
        logic [W-1:0]  dout;
        logic          perr;
        logic          ferr;
    } rx_state_t;

    rx_state_t q, d;
    logic line, bitv;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.sy   = {q.sy[0], rxd};
        line   = q.sy[1];
        bitv   = vote3(q.va, q.vb, line);
        if (!en) begin
            d.busy = 1'b0;
            d.sub  = '0;
            d.idx  = '0;
        end else if (tick) begin
            if (!q.busy) begin
                if (!line) begin
                    d.busy = 1'b1;
                    d.sub  = '0;
                    d.idx  = '0;
                end
            end else begin
                if (q.sub == SUB_END) begin
                    d.sub = '0;
                    d.idx = q.idx + 1'b1;
                end else begin
                    d.sub = q.sub + 1'b1;
                end
                if (q.sub == SMP_A) d.va = line;
                if (q.sub == SMP_B) d.vb = line;
                if (q.sub == SMP_C) begin
                    if (q.idx == '0) begin
                        if (bitv) d.busy = 1'b0;
                    end else if (q.idx <= IDX_DAT) begin
                        d.sh = {bitv, q.sh[W-1:1]};
                    end else if (par_en && q.idx == IDX_PAR) begin
                        d.pbit = bitv;
                    end else begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                        d.dout = q.sh;
                        d.perr = par_en && (q.pbit != ^q.sh);
                        d.ferr = !bitv;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.sy <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign dout = q.dout;
    assign perr = q.perr;
    assign ferr = q.ferr;
endmodule

// File: rtl/uart_core.sv
module uart_core
    import uart_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          rxd,
    output logic          txd,
    output logic          irq_rx,
    output logic          irq_txdone,
    output logic          irq_txempty
);
    typedef struct packed {
        logic [7:0]    ctrl;
        logic          tdre;
        logic          tcpl;
        logic          rdrf;
        logic          fer;
        logic          ove;
        logic          per;
        logic [DW-1:0] rdr;
        logic [DW-1:0] tdr;
        logic          irq_rx;
        logic          irq_tc;
        logic          irq_te;
    } core_state_t;

    core_state_t q, d;
    logic          tx_busy, tx_done, tx_load;
    logic          rx_done, rx_perr, rx_ferr;
    logic [DW-1:0] rx_dout;
    logic          wr_ctrl, wr_stat, wr_tdr, rd_rdr;

    always_comb begin
        wr_ctrl = bus_wr && bus_addr == A_CTRL;
        wr_stat = bus_wr && bus_addr == A_STAT;
        wr_tdr  = bus_wr && bus_addr == A_TXD;
        rd_rdr  = bus_rd && bus_addr == A_RXD;
        tx_load = q.ctrl[C_TXE] && !tx_busy && !q.tdre;

        d = q;
        if (tx_load) d.tdre = 1'b1;
        if (tx_done && q.tdre) d.tcpl = 1'b1;
        if (wr_tdr) begin
            d.tdr  = bus_wdata;
            d.tdre = 1'b0;
            d.tcpl = 1'b0;
        end
        if (wr_ctrl) begin
            d.ctrl = bus_wdata;
            if (q.ctrl[C_TXE] && !bus_wdata[C_TXE]) begin
                d.tdre = 1'b1;
                d.tcpl = 1'b1;
            end
        end
        if (rd_rdr) d.rdrf = 1'b0;
        if (rx_done && q.ctrl[C_RXE]) begin
            if (q.rdrf) begin
                d.ove = 1'b1;
            end else begin
                d.rdr  = rx_dout;
                d.rdrf = 1'b1;
                d.per  = q.per | rx_perr;
                d.fer  = q.fer | rx_ferr;
            end
        end
        if (wr_stat && bus_wdata[7]) begin
            d.per = 1'b0;
            d.ove = 1'b0;
            d.fer = 1'b0;
        end
        d.irq_rx = q.ctrl[C_RIE] && (q.rdrf || q.per || q.ove || q.fer);
        d.irq_tc = q.ctrl[C_TCIE] && q.tcpl;
        d.irq_te = q.ctrl[C_TEIE] && q.tdre;

        case (bus_addr)
            A_CTRL:  bus_rdata = q.ctrl;
            A_STAT:  bus_rdata = {2'b00, q.per, q.ove, q.fer, q.rdrf, q.tcpl, q.tdre};
            A_TXD:   bus_rdata = q.tdr;
            default: bus_rdata = q.rdr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.tdre <= 1'b1;
        end else begin
            q <= d;
        end
    end

    uart_tx #(.W(DW), .R(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(q.ctrl[C_TXE]), .tick(tick16),
        .par_en(q.ctrl[C_PEN]), .load(tx_load), .din(q.tdr),
        .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    uart_rx #(.W(DW), .R(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(q.ctrl[C_RXE]), .tick(tick16),
        .par_en(q.ctrl[C_PEN]), .rxd(rxd), .done(rx_done), .dout(rx_dout),
        .perr(rx_perr), .ferr(rx_ferr)
    );

    assign irq_rx      = q.irq_rx;
    assign irq_txdone  = q.irq_tc;
    assign irq_txempty = q.irq_te;

    AST_TXD_IDLE_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ctrl[C_TXE]) |=> txd); // R7
    AST_TX_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ctrl[C_TXE]) |-> (q.tdre && q.tcpl)); // R7
    AST_RX_OFF_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ctrl[C_RXE] |=> $stable(q.rdr)); // R6
    AST_OVERRUN_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && q.ctrl[C_RXE] && q.rdrf) |=> (q.ove && $stable(q.rdr))); // R5
    AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl[C_RIE] && q.rdrf) |=> irq_rx); // R8
    AST_TE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ctrl[C_TEIE] && q.tdre) |=> irq_txempty); // R10
endmodule

// File: tb/tb_uart_core.sv
`timescale 1ns/1ps
module tb_uart_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       txd, irq_rx, irq_txdone, irq_txempty;
    logic       loop = 1'b0, rxd_drv = 1'b1;
    logic       rxd;
    int         total = 0, bad = 0;
    bit         finished = 0;
    logic [7:0] abort_ctrl = 8'h00;

    assign rxd = loop ? txd : rxd_drv;

    always #2.5 clk = ~clk;

    uart_core dut (
        .clk(clk), .rst_n(rst_n), .tick16(1'b1), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq_rx(irq_rx), .irq_txdone(irq_txdone),
        .irq_txempty(irq_txempty)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic rd_rx(output logic [7:0] v);
        @(negedge clk);
        bus_addr = 2'd3;
        #0.5;
        v = bus_rdata;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_tcpl(input string tag);
        logic [7:0] s;
        int n;
        n = 0;
        s = 8'h00;
        while (n < 1000 && !s[1]) begin
            @(negedge clk);
            peek(2'd1, s);
            n++;
        end
        if (!s[1]) chk(tag, 0, 1);
    endtask

    // frame driven on rxd: glitch_bit>=0 inverts one clock mid-bit; abort_at>=0 writes abort_ctrl
    task automatic send_rx(input logic [7:0] b, input bit pen, input bit badpar,
                           input bit badstop, input int glitch_bit, input int abort_at);
        logic [10:0] fr;
        int nb;
        fr = {1'b1, 1'b1, 1'b1, b, 1'b0};
        if (pen) begin
            fr[9] = ^b ^ badpar;
            fr[10] = !badstop;
            nb = 11;
        end else begin
            fr[9] = !badstop;
            nb = 10;
        end
        for (int i = 0; i < nb; i++) begin
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                rxd_drv = (i == glitch_bit && k == 8) ? ~fr[i] : fr[i];
                if (i == abort_at && k == 0) begin
                    bus_addr = 2'd0; bus_wdata = abort_ctrl; bus_wr = 1'b1;
                end else if (i == abort_at && k == 1) begin
                    bus_wr = 1'b0;
                end
            end
        end
        @(negedge clk);
        rxd_drv = 1'b1;
        clocks(24);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, s, exp_b;
        clocks(4);
        rst_n = 1'b1;
        clocks(2);

        // R1 reset state
        peek(2'd0, v); chk("R1 ctrl", v, 8'h00);
        peek(2'd1, v); chk("R1 status", v, 8'h01);
        chk("R1 txd", txd, 1);
        chk("R1 irqs", {irq_rx, irq_txdone, irq_txempty}, 0);

        // R10 empty interrupt masked, then enabled
        loop = 1'b1;
        wr(2'd0, 8'h38);
        clocks(2);
        chk("R10 masked", irq_txempty, 0);
        wr(2'd0, 8'h39);
        clocks(1);
        chk("R10 enabled", irq_txempty, 1);

        // R11 write clears flags; R2 bit-level check of one frame with parity
        wr(2'd2, 8'hA5);
        peek(2'd1, v); chk("R11 tdre/tcpl cleared", v & 8'h03, 0);
        begin
            logic [10:0] ef;
            int n;
            ef = {1'b1, ^8'hA5, 8'hA5, 1'b0};
            n = 0;
            while (txd && n < 100) begin @(negedge clk); n++; end
            clocks(8);
            for (int i = 0; i < 11; i++) begin
                chk($sformatf("R2 bit%0d", i), txd, ef[i]);
                clocks(16);
            end
        end
        wait_tcpl("R9 complete flag");
        clocks(4);
        peek(2'd1, v); chk("R3 rdrf after frame", v & 8'h3C, 8'h04);
        rd_rx(v); chk("R3 data A5", v, 8'hA5);
        peek(2'd1, v); chk("R3 rdrf cleared by read", v & 8'h04, 0);

        // R9 completion interrupt
        wr(2'd0, 8'h3A);
        clocks(2);
        chk("R9 irq on", irq_txdone, 1);

        // R2/R3 loopback sweep, parity on, every byte
        for (int b = 0; b < 256; b++) begin
            wr(2'd2, 8'(b));
            if (b == 0) begin
                clocks(1);
                chk("R9 irq off after write", irq_txdone, 0);
            end
            wait_tcpl("R2 sweep done");
            clocks(4);
            peek(2'd1, s);
            rd_rx(v);
            chk($sformatf("R2 R3 loop par byte %0d", b), {s & 8'h3C, v}, {8'h04, 8'(b)});
        end

        // loopback without parity
        wr(2'd0, 8'h18);
        for (int b = 0; b < 256; b += 5) begin
            wr(2'd2, 8'(b ^ 8'h5A));
            wait_tcpl("R2 nopar done");
            clocks(4);
            peek(2'd1, s);
            rd_rx(v);
            chk($sformatf("R2 loop nopar byte %0d", b), {s & 8'h3C, v}, {8'h04, 8'(b ^ 8'h5A)});
        end

        // direct receive: parity error, framing error, interrupt, clearing
        loop = 1'b0;
        wr(2'd0, 8'h34);
        clocks(2);
        send_rx(8'h3C, 1, 1, 0, -1, -1);
        peek(2'd1, s); chk("R4 parity error", s & 8'h3C, 8'h24);
        chk("R8 irq_rx", irq_rx, 1);
        rd_rx(v); chk("R4 data kept", v, 8'h3C);
        wr(2'd1, 8'h80);
        clocks(2);
        peek(2'd1, s); chk("R11 errors cleared", s & 8'h3C, 0);
        chk("R8 irq_rx low", irq_rx, 0);
        send_rx(8'hC3, 1, 0, 1, -1, -1);
        peek(2'd1, s); chk("R4 framing error", s & 8'h3C, 8'h0C);
        rd_rx(v);
        wr(2'd1, 8'h80);

        // R3 majority vote rejects one-clock glitch
        for (int g = 1; g <= 9; g++) begin
            exp_b = 8'(8'h69 + g * 13);
            send_rx(exp_b, 1, 0, 0, g, -1);
            peek(2'd1, s);
            rd_rx(v);
            chk($sformatf("R3 glitch bit %0d", g), {s & 8'h3C, v}, {8'h04, exp_b});
        end

        // R5 overrun
        send_rx(8'h11, 1, 0, 0, -1, -1);
        send_rx(8'h22, 1, 0, 0, -1, -1);
        peek(2'd1, s); chk("R5 overrun flags", s & 8'h3C, 8'h14);
        peek(2'd3, v); chk("R5 old byte kept", v, 8'h11);

        // R6 receive abort mid-frame
        abort_ctrl = 8'h24;
        send_rx(8'h77, 1, 0, 0, -1, 5);
        peek(2'd1, s); chk("R6 flags unchanged", s & 8'h3C, 8'h14);
        peek(2'd3, v); chk("R6 data unchanged", v, 8'h11);
        rd_rx(v);
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h34);
        clocks(4);
        send_rx(8'h9E, 1, 0, 0, -1, -1);
        peek(2'd1, s);
        rd_rx(v);
        chk("R6 receive after re-enable", {s & 8'h3C, v}, {8'h04, 8'h9E});

        // R7 transmit abort
        wr(2'd0, 8'h28);
        wr(2'd2, 8'h00);
        clocks(60);
        chk("R7 line busy before abort", txd, 0);
        wr(2'd0, 8'h20);
        peek(2'd1, s); chk("R7 flags set", s & 8'h03, 8'h03);
        @(negedge clk);
        chk("R7 txd idle", txd, 1);
        clocks(40);
        chk("R7 txd stays idle", txd, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule